// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block turns a fast digital reference clock into the processor clock, a slower peripheral clock, and a clean reset and ready pair for the processor. The processor clock runs at one third of the reference frequency. It is high for one reference period and low for the next two. The peripheral clock is the processor clock divided by two, which gives a square wave with equal high and low times. Two ready requests from slow memory or I/O logic are combined and resynchronised to the processor clock. An asynchronous reset request is turned into a reset output that is stretched by a fixed number of processor clock periods. Other devices on the board may share that reset output.

Everything runs on the reference clock. The two generated clocks come straight from registers. The synchronisers that belong to the processor clock advance only on the reference cycle in which the processor clock rises. They therefore sample at processor clock rising edges without a second clock domain.

The phase machine has three states. `PH_HIGH` goes to `PH_LOW_A`, `PH_LOW_A` goes to `PH_LOW_B`, and `PH_LOW_B` goes back to `PH_HIGH`. While the synchronised reset request is active, any state is forced to `PH_LOW_B`. The reset machine also has three states:
- `RS_FORCE` moves to `RS_HOLD` on the first processor clock rise after the request clears.
- `RS_HOLD` counts further rises and moves to `RS_RUN` after the hold count.
- Any state goes back to `RS_FORCE` when the request returns.

Top module: `clkgen_top`

## Requirements
- R1: `cpu_clk` repeats every 3 reference cycles and is high for exactly 1 of them.
- R2: `per_clk` changes only in the reference cycle where `cpu_clk` falls. In steady state it is high for 3 reference cycles and low for 3.
- R3: Ready inputs are active high. `rdy_out` follows the logical OR of `rdy_req_a` and `rdy_req_b`.
- R4: The merged ready passes through a two-stage synchroniser that advances at `cpu_clk` rising edges. A change held across two rises appears at the second rise. A request that rises and falls between two rises is never seen.
- R5: Raising `rst_req` forces `rst_out`=1, `cpu_clk`=0, `per_clk`=0 and `rdy_out`=0 at once, without waiting for a clock edge.
- R6: While the synchronised request is active, `cpu_clk` stays low. After `rst_req` falls, the first `cpu_clk` rise comes on the third reference rising edge.
- R7: `rst_out` stays 1 through the first 4 `cpu_clk` rises after release. It falls at the 5th rise, which is the same edge where `cpu_clk` rises (HOLD_CLKS=4).
- R8: A request held across only one reference edge still produces the full R6/R7 release sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, three times the processor clock rate |
| rst_req | input | 1 | Asynchronous reset request, active high |
| rdy_req_a | input | 1 | First ready request, active high |
| rdy_req_b | input | 1 | Second ready request, active high |
| cpu_clk | output | 1 | Processor clock, one-third duty |
| per_clk | output | 1 | Peripheral clock, half the processor clock rate, 50% duty |
| rst_out | output | 1 | Stretched reset output, active high |
| rdy_out | output | 1 | Synchronised ready, active high |

## Verification
The hardest case to reach is a ready request that lives entirely inside the low phase of the processor clock. The bench waits for a `cpu_clk` rise, then raises and drops a request within one reference cycle, well before the next rise. It then watches `rdy_out` across three further rises. A second hard case is a reset request as short as one reference cycle. The bench releases it on the very next falling reference edge and counts processor clock rises until `rst_out` falls.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_LOW_A = 2'd1,
        PH_LOW_B = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RS_FORCE = 2'd0,
        RS_HOLD  = 2'd1,
        RS_RUN   = 2'd2
    } rst_state_e;

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
    parameter int STAGES  = 2,
    parameter bit CLR_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge arst) begin
                if (arst)    sr_q <= CLR_VAL;
                else if (en) sr_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or posedge arst) begin
                if (arst)    sr_q <= {STAGES{CLR_VAL}};
                else if (en) sr_q <= {sr_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[STAGES-1];

    initial begin
        assert (STAGES >= 1);
    end
endmodule

// File: rtl/clkgen_phase.sv
module clkgen_phase
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic hold,
    output logic cpu_clk,
    output logic per_clk,
    output logic rise_en
);
    phase_e state_q, state_d;
    logic   cpu_q, per_q;
    logic   fall_en;

    // next-state logic
    always_comb begin
        if (hold) begin
            state_d = PH_LOW_B;
        end else begin
            unique case (state_q)
                PH_HIGH:  state_d = PH_LOW_A;
                PH_LOW_A: state_d = PH_LOW_B;
                PH_LOW_B: state_d = PH_HIGH;
                default:  state_d = PH_LOW_B;
            endcase
        end
    end

    assign rise_en = (state_d == PH_HIGH) && (state_q != PH_HIGH);
    assign fall_en = (state_q == PH_HIGH) && (state_d != PH_HIGH);

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= PH_LOW_B;
        else      state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cpu_q <= 1'b0;
            per_q <= 1'b0;
        end else begin
            cpu_q <= (state_d == PH_HIGH);
            if (hold)         per_q <= 1'b0;
            else if (fall_en) per_q <= ~per_q;
        end
    end

    assign cpu_clk = cpu_q;
    assign per_clk = per_q;

    AST_CLK_HIGH_ONE: assert property (@(posedge clk) disable iff (arst)
        cpu_q |=> !cpu_q); // R1
    AST_CLK_LOW_TWO: assert property (@(posedge clk) disable iff (arst || hold)
        $fell(cpu_q) |=> !cpu_q); // R1
    AST_CLK_PERIOD: assert property (@(posedge clk) disable iff (arst || hold)
        $fell(cpu_q) |=> ##1 cpu_q); // R1
    AST_PCLK_ON_FALL: assert property (@(posedge clk) disable iff (arst)
        !$stable(per_q) |-> $fell(cpu_q)); // R2
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (arst)
        hold |=> !cpu_q); // R6
endmodule

// File: rtl/clkgen_rstgen.sv
module clkgen_rstgen
    import clkgen_pkg::*;
#(
    parameter int HOLD_CLKS = 4
) (
    input  logic clk,
    input  logic arst,
    input  logic req,
    input  logic tick,
    output logic rst_out
);
    localparam int CNT_W = $clog2(HOLD_CLKS + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CLKS);

    rst_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rst_q;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RS_FORCE: begin
                cnt_d = '0;
                if (!req && tick) begin
                    st_d  = RS_HOLD;
                    cnt_d = CNT_W'(1);
                end
            end
            RS_HOLD: begin
                if (req) begin
                    st_d  = RS_FORCE;
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q >= HOLD_V) begin
                        st_d  = RS_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            RS_RUN: begin
                cnt_d = '0;
                if (req) st_d = RS_FORCE;
            end
            default: begin
                st_d  = RS_FORCE;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q  <= RS_FORCE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) rst_q <= 1'b1;
        else      rst_q <= (st_d != RS_RUN);
    end

    assign rst_out = rst_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (arst)
        cnt_q <= HOLD_V); // R7
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (arst)
        $fell(rst_q) |-> $past(tick)); // R7
    AST_REQ_KEEPS_RST: assert property (@(posedge clk) disable iff (arst)
        req |=> rst_q); // R5
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CLKS   = 4
) (
    input  logic ref_clk,
    input  logic rst_req,
    input  logic rdy_req_a,
    input  logic rdy_req_b,
    output logic cpu_clk,
    output logic per_clk,
    output logic rst_out,
    output logic rdy_out
);
    logic req_s;
    logic rise_en;
    logic rdy_any;

    assign rdy_any = rdy_req_a | rdy_req_b;

    clkgen_sync #(.STAGES(SYNC_STAGES), .CLR_VAL(1'b1)) u_req_sync (
        .clk (ref_clk),
        .arst(rst_req),
        .en  (1'b1),
        .d   (1'b0),
        .q   (req_s)
    );

    clkgen_phase u_phase (
        .clk    (ref_clk),
        .arst   (rst_req),
        .hold   (req_s),
        .cpu_clk(cpu_clk),
        .per_clk(per_clk),
        .rise_en(rise_en)
    );

    clkgen_rstgen #(.HOLD_CLKS(HOLD_CLKS)) u_rst (
        .clk    (ref_clk),
        .arst   (rst_req),
        .req    (req_s),
        .tick   (rise_en),
        .rst_out(rst_out)
    );

    clkgen_sync #(.STAGES(2), .CLR_VAL(1'b0)) u_rdy_sync (
        .clk (ref_clk),
        .arst(rst_req),
        .en  (rise_en),
        .d   (rdy_any),
        .q   (rdy_out)
    );

    AST_RDY_ON_RISE: assert property (@(posedge ref_clk) disable iff (rst_req)
        !$stable(rdy_out) |-> $rose(cpu_clk)); // R4
    AST_RST_WITH_CLK: assert property (@(posedge ref_clk) disable iff (rst_req)
        $fell(rst_out) |-> $rose(cpu_clk)); // R7
    AST_RDY_NEEDS_REQ: assert property (@(posedge ref_clk) disable iff (rst_req)
        $rose(rdy_out) |-> $past(rdy_any, 3) || $past(rdy_any, 4) || $past(rdy_any, 5)
                           || $past(rdy_any, 6)); // R3
endmodule

// File: tb/sim_clkgen_top.sv
module sim_clkgen_top;
    logic ref_clk = 1'b0;
    logic rst_req = 1'b1;
    logic rdy_req_a = 1'b0;
    logic rdy_req_b = 1'b0;
    logic cpu_clk, per_clk, rst_out, rdy_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 ref_clk = ~ref_clk;

    clkgen_top u0 (
        .ref_clk  (ref_clk),
        .rst_req  (rst_req),
        .rdy_req_a(rdy_req_a),
        .rdy_req_b(rdy_req_b),
        .cpu_clk  (cpu_clk),
        .per_clk  (per_clk),
        .rst_out  (rst_out),
        .rdy_out  (rdy_out)
    );

    // {a, b, expected rdy_out}
    localparam logic [2:0] VEC [8] = '{
        3'b000, 3'b101, 3'b000, 3'b011, 3'b111, 3'b011, 3'b000, 3'b111
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        @(posedge cpu_clk);
        @(negedge ref_clk);
    endtask

    task automatic release_and_count(input string tag);
        @(negedge ref_clk);
        rst_req = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge ref_clk);
            #1;
            chk({tag, " R6 first rise on third edge"}, cpu_clk, (k == 3) ? 1 : 0);
        end
        chk({tag, " R7 reset after rise 1"}, rst_out, 1);
        for (int n = 2; n <= 5; n++) begin
            @(posedge cpu_clk);
            #1;
            chk({tag, " R7 reset after rise"}, rst_out, (n < 5) ? 1 : 0);
        end
    endtask

    initial begin
        int highs, trans;
        logic pc, pp;
        logic prev_exp;
        // reset state
        repeat (3) @(negedge ref_clk);
        chk("R5 rst_out in reset", rst_out, 1);
        chk("R5 rdy_out in reset", rdy_out, 0);
        chk("R5 per_clk in reset", per_clk, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge ref_clk);
            chk("R6 cpu_clk held low", cpu_clk, 0);
        end

        release_and_count("long");

        // R1: duty and period
        @(posedge cpu_clk);
        for (int i = 0; i < 9; i++) begin
            @(negedge ref_clk);
            chk("R1 cpu_clk pattern", cpu_clk, (i % 3 == 0) ? 1 : 0);
        end

        // R2: peripheral clock
        highs = 0; trans = 0;
        @(negedge ref_clk);
        pc = cpu_clk; pp = per_clk;
        for (int i = 0; i < 12; i++) begin
            @(negedge ref_clk);
            if (per_clk !== pp) begin
                trans++;
                chk("R2 per_clk moves on cpu_clk fall", (pc && !cpu_clk) ? 1 : 0, 1);
            end
            if (per_clk) highs++;
            pc = cpu_clk; pp = per_clk;
        end
        chk("R2 per_clk high count", highs, 6);
        chk("R2 per_clk transitions", trans, 4);

        // R3/R4 vector table
        prev_exp = 1'b0;
        wait_rise();
        for (int v = 0; v < 8; v++) begin
            rdy_req_a = VEC[v][2];
            rdy_req_b = VEC[v][1];
            wait_rise();
            chk("R4 no change after one rise", rdy_out, prev_exp);
            wait_rise();
            chk("R3 merged ready", rdy_out, VEC[v][0]);
            prev_exp = VEC[v][0];
        end
        rdy_req_a = 1'b0; rdy_req_b = 1'b0;
        wait_rise(); wait_rise();
        chk("R3 ready cleared", rdy_out, 0);

        // R4 pulse between rises is not seen
        wait_rise();
        rdy_req_b = 1'b1;
        @(negedge ref_clk);
        rdy_req_b = 1'b0;
        for (int i = 0; i < 3; i++) begin
            wait_rise();
            chk("R4 short pulse ignored", rdy_out, 0);
        end

        // R5 mid-run reset
        rdy_req_a = 1'b1;
        wait_rise(); wait_rise();
        chk("R3 ready before reset", rdy_out, 1);
        @(posedge cpu_clk);
        #1;
        rst_req = 1'b1;
        #1;
        chk("R5 cpu_clk forced low", cpu_clk, 0);
        chk("R5 rst_out forced high", rst_out, 1);
        chk("R5 rdy_out forced low", rdy_out, 0);
        chk("R5 per_clk forced low", per_clk, 0);
        rdy_req_a = 1'b0;

        // R8 one-edge reset request
        release_and_count("R8 short");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge ref_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule